// File: doc/BRIEF.md
# Converter-Style Serial Command Slave

This block is the digital side of a data converter's 3-wire serial port. A host drives a serial clock, a data line and an active-low select. The block gathers command bytes from the data line and sorts each one by its leading bits into a conversion request, a setup write, an averaging write or a reset. It keeps the configuration fields those bytes carry, and it returns conversion results on the output line. The analog converter is outside the block. A parallel result input stands in for it, and a one-cycle start pulse with a channel number tells that converter what was asked for.

Serial signals are brought into the system clock domain, and their edges are detected there. The host may idle the serial clock either low or high. In both cases data is taken on the rising edge and the output moves on the falling edge. A setup byte can arm a write of the byte that follows it in the same select window. That byte goes to either the unipolar pair register or the bipolar pair register. A channel whose pair is marked bipolar returns its result in two's complement. Every other channel returns straight binary.

Top module: `spi_cmd_slave`

## Requirements
- R1: While cs_ni is low, din_i is sampled on each rising sclk_i edge. Eight samples form one byte, with the first sample as bit 7.
- R2: A setup byte has bits 7:6 = 01. It loads clk_mode_o from bits 5:4, with bit 5 as the upper bit, and it loads ref_sel_o from bits 3:2.
- R3: In a setup byte, bits 1:0 = 10 make the next complete byte in the same select window load uni_mode_o. Bits 1:0 = 11 make that byte load bip_mode_o. With any other value of bits 1:0, the next byte is decoded as a command.
- R4: A conversion byte has bit 7 = 1. It raises conv_start_o for exactly one clock, sets chan_o to bits 6:3, and captures result_i.
- R5: Each select window shifts out a 16-bit frame on dout_o, MSB first: four zeros, then the captured 12-bit result. The first bit is present before the first rising edge. Each later bit appears after a falling edge that follows a rising edge.
- R6: When bit chan[3:1] of bip_mode_o is set at capture time, the result is sent in two's complement, which is result_i with bit 11 inverted. Otherwise result_i is sent unchanged.
- R7: An averaging byte has bits 7:5 = 001. It loads avg_cfg_o from bits 4:0.
- R8: A reset byte has bits 7:4 = 0001. It returns the configuration to its defaults: clk_mode_o = 10, and ref_sel_o, uni_mode_o, bip_mode_o and avg_cfg_o all zero.
- R9: A byte with bits 7:4 = 0000 changes no configuration output and raises no conversion start.
- R10: cs_ni going high discards a partial byte, restarts bit counting, and cancels an armed second-byte write.
- R11: Results and register writes are the same whether sclk_i idles low or high.
- R12: After reset, dout_o = 0, conv_start_o = 0, chan_o = 0, clk_mode_o = 10, and all other configuration outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host |
| cs_ni | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out |
| result_i | input | 12 | Parallel conversion result, offset binary |
| conv_start_o | output | 1 | One-cycle conversion request |
| chan_o | output | 4 | Requested channel |
| clk_mode_o | output | 2 | Stored clock-mode select |
| ref_sel_o | output | 2 | Stored reference select |
| uni_mode_o | output | 8 | Unipolar pair register |
| bip_mode_o | output | 8 | Bipolar pair register |
| avg_cfg_o | output | 5 | Stored averaging field |

## Verification
The byte decoder is driven with one byte of each kind and with an ignored pattern. Setup bytes cover all three second-byte choices, so the tests show whether the follow-on byte reaches the unipolar register, the bipolar register or the ordinary decoder. Results are read from channels on bipolar and non-bipolar pairs, with codes 0x123, 0x800 and 0xFFF, under both clock idle levels. This separates binary from two's complement, shows whether the MSB is inverted, and checks the bit order. Interrupted bytes and armed setups cut off by a select rise are followed by clean bytes, which shows whether stale bit counts or pending writes survive.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int RES_W   = 12;
  localparam int FRAME_W = 16;
  localparam int CH_W    = 4;
  localparam logic [1:0] CLK_MODE_RST = 2'b10;

  typedef enum logic [2:0] {
    BK_NONE, BK_CONV, BK_SETUP, BK_AVG, BK_RESET
  } byte_kind_e;

  function automatic byte_kind_e classify(input logic [BYTE_W-1:0] b);
    if (b[7])      return BK_CONV;
    else if (b[6]) return BK_SETUP;
    else if (b[5]) return BK_AVG;
    else if (b[4]) return BK_RESET;
    else           return BK_NONE;
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic din_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_idle_o,
  output logic din_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sclk_p, cs_p, din_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= '0;
      cs_p   <= '1;
      din_p  <= '0;
    end else begin
      sclk_p <= {sclk_p[LAST-1:0], sclk_i};
      cs_p   <= {cs_p[LAST-1:0], cs_ni};
      din_p  <= {din_p[LAST-1:0], din_i};
    end
  end

  assign sclk_rise_o = sclk_p[LAST-1] & ~sclk_p[LAST];
  assign sclk_fall_o = ~sclk_p[LAST-1] & sclk_p[LAST];
  assign cs_fall_o   = ~cs_p[LAST-1] & cs_p[LAST];
  assign cs_idle_o   = cs_p[LAST-1];
  // din aligned with the sclk stage used for edge detection
  assign din_o       = din_p[LAST-1];
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              din_i,
  input  logic              cs_idle_i,
  output logic              byte_valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] rx_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt      <= '0;
      rx_sr        <= '0;
      byte_valid_o <= 1'b0;
      byte_o       <= '0;
    end else begin
      byte_valid_o <= 1'b0;
      if (cs_idle_i) begin
        bit_cnt <= '0;
      end else if (rise_i) begin
        rx_sr   <= {rx_sr[BYTE_W-3:0], din_i};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_LAST) begin
          byte_valid_o <= 1'b1;
          byte_o       <= {rx_sr, din_i};
        end
      end
    end
  end

  // R10
  idle_no_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_idle_i |=> !byte_valid_o);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cs_idle_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [1:0]        clk_mode_o,
  output logic [1:0]        ref_sel_o,
  output logic [BYTE_W-1:0] uni_mode_o,
  output logic [BYTE_W-1:0] bip_mode_o,
  output logic [4:0]        avg_cfg_o,
  output logic [RES_W-1:0]  result_q_o
);
  localparam logic [RES_W-1:0] SIGN_FLIP = RES_W'(1) << (RES_W - 1);

  logic       pend_q, pend_bip_q;
  logic [CH_W-1:0] new_chan;
  byte_kind_e kind;

  assign kind     = classify(byte_i);
  assign new_chan = byte_i[BYTE_W-2 -: CH_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_bip_q   <= 1'b0;
      conv_start_o <= 1'b0;
      chan_o       <= '0;
      clk_mode_o   <= CLK_MODE_RST;
      ref_sel_o    <= '0;
      uni_mode_o   <= '0;
      bip_mode_o   <= '0;
      avg_cfg_o    <= '0;
      result_q_o   <= '0;
    end else begin
      conv_start_o <= 1'b0;
      if (cs_idle_i) pend_q <= 1'b0;
      if (byte_valid_i) begin
        if (pend_q) begin
          if (pend_bip_q) bip_mode_o <= byte_i;
          else            uni_mode_o <= byte_i;
          pend_q <= 1'b0;
        end else begin
          unique case (kind)
            BK_CONV: begin
              conv_start_o <= 1'b1;
              chan_o       <= new_chan;
              result_q_o   <= bip_mode_o[new_chan[CH_W-1:1]] ? (result_i ^ SIGN_FLIP)
                                                             : result_i;
            end
            BK_SETUP: begin
              clk_mode_o <= byte_i[5:4];
              ref_sel_o  <= byte_i[3:2];
              pend_q     <= byte_i[1];
              pend_bip_q <= byte_i[0];
            end
            BK_AVG: avg_cfg_o <= byte_i[4:0];
            BK_RESET: begin
              clk_mode_o <= CLK_MODE_RST;
              ref_sel_o  <= '0;
              uni_mode_o <= '0;
              bip_mode_o <= '0;
              avg_cfg_o  <= '0;
            end
            BK_NONE: ;
            default: ;
          endcase
        end
      end
    end
  end

  // R4
  conv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_i |=> $stable(clk_mode_o));

  // R9
  ignore_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && byte_i[7:4] == 4'b0000 && !pend_q) |=>
      ($stable({clk_mode_o, ref_sel_o, uni_mode_o, bip_mode_o, avg_cfg_o}) && !conv_start_o));
endmodule

// File: rtl/spi_tx_frame.sv
module spi_tx_frame
  import spi_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_idle_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o
);
  localparam int PAD_W = FRAME_W - RES_W;

  logic [FRAME_W-1:0] tx_sr;
  logic               rose_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sr  <= '0;
      rose_q <= 1'b0;
    end else if (cs_fall_i) begin
      tx_sr  <= {{PAD_W{1'b0}}, result_i};
      rose_q <= 1'b0;
    end else if (!cs_idle_i) begin
      if (rise_i) rose_q <= 1'b1;
      // idle-high clock: the opening fall precedes any rise and must not shift
      if (fall_i && rose_q) tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
    end
  end

  assign dout_o = tx_sr[FRAME_W-1];

  // R5
  dout_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_i && !cs_fall_i) |=> $stable(dout_o));

  // R5
  pad_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> !dout_o);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              din_i,
  output logic              dout_o,
  input  logic [RES_W-1:0]  result_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [1:0]        clk_mode_o,
  output logic [1:0]        ref_sel_o,
  output logic [BYTE_W-1:0] uni_mode_o,
  output logic [BYTE_W-1:0] bip_mode_o,
  output logic [4:0]        avg_cfg_o
);
  logic              rise, fall, cs_fall, cs_idle, din_s;
  logic              byte_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic [RES_W-1:0]  result_q;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .din_i,
    .sclk_rise_o(rise), .sclk_fall_o(fall), .cs_fall_o(cs_fall),
    .cs_idle_o(cs_idle), .din_o(din_s)
  );

  spi_rx_byte u_rx (
    .clk_i, .rst_ni, .rise_i(rise), .din_i(din_s), .cs_idle_i(cs_idle),
    .byte_valid_o(byte_valid), .byte_o(rx_byte)
  );

  spi_cmd_regs u_regs (
    .clk_i, .rst_ni, .byte_valid_i(byte_valid), .byte_i(rx_byte),
    .cs_idle_i(cs_idle), .result_i,
    .conv_start_o, .chan_o, .clk_mode_o, .ref_sel_o,
    .uni_mode_o, .bip_mode_o, .avg_cfg_o, .result_q_o(result_q)
  );

  spi_tx_frame u_tx (
    .clk_i, .rst_ni, .cs_fall_i(cs_fall), .cs_idle_i(cs_idle),
    .rise_i(rise), .fall_i(fall), .result_i(result_q), .dout_o
  );
endmodule

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, conv_start;
  logic [11:0] result = '0;
  logic [3:0] chan;
  logic [1:0] clk_mode, ref_sel;
  logic [7:0] uni_mode, bip_mode;
  logic [4:0] avg_cfg;

  int n_chk = 0, n_fail = 0, n_conv = 0;
  bit done = 0;
  bit cpol = 0;
  logic [7:0] bip_m = '0;
  logic [15:0] exp_q[$];
  logic [15:0] obs_q[$];

  spi_cmd_slave dut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .cs_ni(cs_n), .din_i(din), .dout_o(dout),
    .result_i(result), .conv_start_o(conv_start), .chan_o(chan),
    .clk_mode_o(clk_mode), .ref_sel_o(ref_sel), .uni_mode_o(uni_mode),
    .bip_mode_o(bip_mode), .avg_cfg_o(avg_cfg)
  );

  always #5 clk = ~clk;
  always @(posedge clk) if (conv_start) n_conv++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic win_open();
    sclk = cpol; #100; cs_n = 1'b0; #100;
  endtask

  task automatic win_close();
    sclk = cpol; #80; cs_n = 1'b1; #200;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; #40; din = tx[i]; #40;
      rx[i] = dout; sclk = 1'b1; #80;
    end
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; #40; din = 1'b1; #40; sclk = 1'b1; #80;
    end
  endtask

  task automatic send1(input logic [7:0] b);
    logic [7:0] r;
    win_open(); xfer(b, r); win_close();
  endtask

  task automatic send2(input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] r;
    win_open(); xfer(b0, r); xfer(b1, r); win_close();
  endtask

  // driver: request conversion and push the expected frame
  task automatic convert(input logic [3:0] ch, input logic [11:0] res);
    result = res;
    send1({1'b1, ch, 3'b000});
    exp_q.push_back({4'h0, bip_m[ch[3:1]] ? (res ^ 12'h800) : res});
  endtask

  task automatic read_frame();
    logic [7:0] hi, lo;
    win_open(); xfer(8'h00, hi); xfer(8'h00, lo); win_close();
    obs_q.push_back({hi, lo});
  endtask

  // monitor / scoreboard
  initial forever begin
    wait (obs_q.size() > 0);
    begin
      logic [15:0] o, e;
      o = obs_q.pop_front();
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hxxxx;
      chk("R5 R6 R11 frame", {16'h0, o}, {16'h0, e});
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0;
    #30 rst_ni = 1'b1; #40;
    // R12 reset state
    chk("R12 dout", dout, 0);
    chk("R12 conv_start", conv_start, 0);
    chk("R12 chan", chan, 0);
    chk("R12 clk_mode", clk_mode, 2'b10);
    chk("R12 cfg", {ref_sel, uni_mode, bip_mode, avg_cfg}, 0);

    // R1 R2 R3: setup with bipolar follow-on
    send2(8'h5B, 8'h0C); bip_m = 8'h0C;
    chk("R2 clk_mode", clk_mode, 2'b01);
    chk("R2 ref_sel", ref_sel, 2'b10);
    chk("R3 bip", bip_mode, 8'h0C);
    chk("R3 uni untouched", uni_mode, 0);

    // R3 unipolar follow-on, idle-high clock (R11)
    cpol = 1;
    send2(8'h72, 8'hA5);
    chk("R3 uni", uni_mode, 8'hA5);
    chk("R2 clk_mode 11", clk_mode, 2'b11);
    chk("R3 bip kept", bip_mode, 8'h0C);
    cpol = 0;

    // R3 no follow-on: second byte decoded as averaging (R7)
    send2(8'h61, 8'h3A);
    chk("R7 avg", avg_cfg, 5'h1A);
    chk("R3 uni kept", uni_mode, 8'hA5);
    chk("R2 clk_mode 10", clk_mode, 2'b10);

    // R9 ignored byte
    c0 = n_conv;
    send1(8'h07);
    chk("R9 cfg", {clk_mode, ref_sel, uni_mode, bip_mode, avg_cfg}, {2'b10, 2'b00, 8'hA5, 8'h0C, 5'h1A});
    chk("R9 no conv", n_conv, c0);

    // R4 R5 R6 conversions and reads
    c0 = n_conv;
    convert(4'd2, 12'h123);
    chk("R4 pulse", n_conv, c0 + 1);
    chk("R4 chan", chan, 4'd2);
    read_frame();
    convert(4'd5, 12'h123);
    chk("R4 chan 5", chan, 4'd5);
    cpol = 1; read_frame(); cpol = 0;
    convert(4'd6, 12'h800);
    cpol = 1; read_frame(); cpol = 0;
    convert(4'd0, 12'hFFF);
    read_frame();

    // R10 partial byte discarded
    win_open(); bits(5); win_close();
    send1(8'h4C);
    chk("R10 clk_mode", clk_mode, 2'b00);
    chk("R10 ref_sel", ref_sel, 2'b11);
    // R10 armed write cancelled by select rise
    send1(8'h43);
    send1(8'h25);
    chk("R10 avg", avg_cfg, 5'h05);
    chk("R10 bip kept", bip_mode, 8'h0C);

    // R8 reset byte
    send1(8'h10); bip_m = '0;
    chk("R8 clk_mode", clk_mode, 2'b10);
    chk("R8 cfg", {ref_sel, uni_mode, bip_mode, avg_cfg}, 0);
    convert(4'd6, 12'h800);
    read_frame();

    wait (obs_q.size() == 0);
    #100;
    chk("R5 all frames consumed", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule